// File: doc/BRIEF.md
# Registered Bidirectional Gray Code Converter

A clocked converter between plain binary and reflected Gray code on a 4-bit word, with bit 3 as the most significant bit. A direction input selects the conversion. When it is 0 the block encodes binary to Gray. When it is 1 the block decodes Gray to binary. The word, the direction bit and a strobe are captured together on one rising clock edge. The converted word is registered on the following edge. The result therefore reaches the output pins two edges after it was presented.

Both directions share one exclusive-OR chain. The top bit passes straight through in both directions. Each lower bit is the exclusive-OR of its own input bit and a second operand. In encode mode the second operand is the raw input bit one position higher. In decode mode it is the result already computed for that higher bit, so the chain forms a running exclusive-OR from the top bit down. For the bit just below the top, the two choices are the same signal, so only the two lowest bits need a multiplexer. A valid flag follows the strobe through both register stages. It marks the cycles in which the output belongs to a strobed input.

Top module: `gray_bidir_conv`

## Requirements
- R1: While `rst` is high at a rising edge, all nine data and mode registers are cleared to zero and `out_valid` is cleared. After the edge, `data_out` reads 0000 and `out_valid` reads 0.
- R2: In encode mode (`mode_dec` = 0), `data_out[3]` equals input bit 3, and for i = 2, 1, 0, `data_out[i]` equals input bit i+1 XOR input bit i.
- R3: In decode mode (`mode_dec` = 1), `data_out[3]` equals input bit 3, and for i = 2, 1, 0, `data_out[i]` equals the XOR of input bits 3 down to i.
- R4: Binary 0110 encodes to 0101. Gray 0101 decodes to 0110. Binary 0101 encodes to 0111.
- R5: The inputs present at rising edge k appear converted on `data_out` after edge k+1. `out_valid` is high after edge k+1 exactly when `in_strobe` was high at edge k.
- R6: The direction bit is captured at the same edge as its data word. A change of `mode_dec` in the next cycle has no effect on the result for that word.
- R7: For every one of the 16 values, encoding and then decoding the result returns the original value.
- R8: The Gray codes of consecutive binary values differ in exactly one bit. This includes the wrap from 15 back to 0.
- R9: `data_out` is updated on every edge, whether or not the strobe was set. When the strobe was low two edges earlier, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_strobe | input | 1 | Marks `data_in` as a word to convert |
| mode_dec | input | 1 | 0 = binary to Gray, 1 = Gray to binary |
| data_in | input | 4 | Word to convert, bit 3 most significant |
| data_out | output | 4 | Converted word, registered |
| out_valid | output | 1 | High when `data_out` belongs to a strobed word |

## Verification
Every result is due two rising edges after its inputs were driven: one edge captures the inputs and the next registers the converted word and the delayed strobe. The bench drives inputs on falling edges. On each falling edge it compares `data_out` and `out_valid` against an expectation queued two steps earlier, so inputs can change every cycle while each comparison still lines up with the word that produced it. The round-trip and single-bit-change checks reuse the Gray codes that the design itself produced during an encode sweep, so both directions are compared through the ports.

// File: rtl/gray_pkg.sv
package gray_pkg;

    // Width of the converted word.
    localparam int GC_W = 4;

    // Conversion direction.
    typedef enum logic {
        MODE_ENC = 1'b0,
        MODE_DEC = 1'b1
    } conv_mode_e;

    // Binary to reflected Gray.
    function automatic logic [GC_W-1:0] bin_to_gray(input logic [GC_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Number of set bits in a word.
    function automatic int unsigned ones_in(input logic [GC_W-1:0] w);
        int unsigned n;
        n = 0;
        for (int i = 0; i < GC_W; i++) begin
            n += int'(w[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/gc_capture.sv
module gc_capture
    import gray_pkg::*;
#(
    parameter int WIDTH = GC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_in,
    input  logic             mode_in,
    input  logic [WIDTH-1:0] word_in,
    output logic [WIDTH-1:0] word_q,
    output conv_mode_e       mode_q,
    output logic             vld_q
);

    // First register stage: the word, the direction and the strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            mode_q <= MODE_ENC;
            vld_q  <= 1'b0;
        end else begin
            word_q <= word_in;
            mode_q <= conv_mode_e'(mode_in);
            vld_q  <= strobe_in;
        end
    end

    // R6: the direction is taken at the same edge as its word.
    assert_mode_capture_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mode_q == conv_mode_e'($past(mode_in))) && (word_q == $past(word_in)));

endmodule

// File: rtl/gc_xor_chain.sv
module gc_xor_chain
    import gray_pkg::*;
#(
    parameter int WIDTH = GC_W
) (
    input  logic [WIDTH-1:0] src,
    input  conv_mode_e       mode,
    output logic [WIDTH-1:0] res
);

    // Walk from the top bit down. The second operand of each lower bit
    // is either the raw neighbour above (encode) or the result just
    // produced for that neighbour (decode). The bit right below the top
    // sees the same value both ways, so only the lower bits need a mux.
    always_comb begin
        logic carry;
        logic opnd;
        carry        = src[WIDTH-1];
        res          = '0;
        res[WIDTH-1] = src[WIDTH-1];
        for (int i = WIDTH - 2; i >= 0; i--) begin
            if (i == WIDTH - 2 || mode == MODE_ENC) begin
                opnd = src[i+1];
            end else begin
                opnd = carry;
            end
            carry  = src[i] ^ opnd;
            res[i] = carry;
        end
    end

endmodule

// File: rtl/gc_result_reg.sv
module gc_result_reg
    import gray_pkg::*;
#(
    parameter int WIDTH = GC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] res_in,
    input  logic             vld_in,
    output logic [WIDTH-1:0] res_q,
    output logic             vld_q
);

    // Second register stage. The word updates on every edge; the flag
    // tells whether it came from a strobed input.
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            res_q <= res_in;
            vld_q <= vld_in;
        end
    end

    // R5: the flag advances exactly one stage per edge.
    assert_valid_follow_R5: assert property (@(posedge clk) disable iff (rst)
        vld_in |=> vld_q);
    // R9: no strobe means no valid output.
    assert_valid_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !vld_in |=> !vld_q);

endmodule

// File: rtl/gray_bidir_conv.sv
module gray_bidir_conv
    import gray_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_strobe,
    input  logic          mode_dec,
    input  logic [3:0]    data_in,
    output logic [3:0]    data_out,
    output logic          out_valid
);

    localparam int W = GC_W;

    logic [W-1:0] a_word;
    conv_mode_e   a_mode;
    logic         a_vld;
    logic [W-1:0] chain_res;

    gc_capture #(.WIDTH(W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (in_strobe),
        .mode_in   (mode_dec),
        .word_in   (data_in),
        .word_q    (a_word),
        .mode_q    (a_mode),
        .vld_q     (a_vld)
    );

    gc_xor_chain #(.WIDTH(W)) u_chain (
        .src  (a_word),
        .mode (a_mode),
        .res  (chain_res)
    );

    gc_result_reg #(.WIDTH(W)) u_result (
        .clk    (clk),
        .rst    (rst),
        .res_in (chain_res),
        .vld_in (a_vld),
        .res_q  (data_out),
        .vld_q  (out_valid)
    );

    // R1: reset empties the output stage.
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (data_out == '0) && !out_valid);

    // R2: an encoded word matches the adjacent-bit XOR of its source.
    assert_encode_R2: assert property (@(posedge clk) disable iff (rst)
        (a_mode == MODE_ENC) |=> data_out == bin_to_gray($past(a_word)));

    // R3: a decoded word re-encodes to the Gray word it came from.
    assert_decode_R3: assert property (@(posedge clk) disable iff (rst)
        (a_mode == MODE_DEC) |=> bin_to_gray(data_out) == $past(a_word));

    // R3: the top bit passes straight through in both directions.
    assert_top_bit_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> data_out[W-1] == $past(a_word[W-1]));

endmodule

// File: tb/tb_gray_bidir_conv.sv
`timescale 1ns/1ps
module tb_gray_bidir_conv;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_strobe = 1'b0;
    logic       mode_dec = 1'b0;
    logic [3:0] data_in = 4'h0;
    logic [3:0] data_out;
    logic       out_valid;

    int n_cmp = 0;
    int n_bad = 0;

    // Expectations two steps deep: [0] = last step, [1] = the one before.
    logic [3:0] exp_d [2];
    logic       exp_v [2];
    string      exp_t [2];

    logic [3:0] gray_cap [17];
    int         cap_idx = 0;
    bit         capturing = 1'b0;

    always #5 clk = ~clk;

    gray_bidir_conv dut (
        .clk       (clk),
        .rst       (rst),
        .in_strobe (in_strobe),
        .mode_dec  (mode_dec),
        .data_in   (data_in),
        .data_out  (data_out),
        .out_valid (out_valid)
    );

    function automatic logic [3:0] ref_enc(input logic [3:0] b);
        logic [3:0] g;
        g[3] = b[3];
        for (int i = 2; i >= 0; i--) g[i] = b[i+1] ^ b[i];
        return g;
    endfunction

    function automatic logic [3:0] ref_dec(input logic [3:0] g);
        logic [3:0] b;
        logic acc;
        acc = 1'b0;
        for (int i = 3; i >= 0; i--) begin
            acc  = acc ^ g[i];
            b[i] = acc;
        end
        return b;
    endfunction

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] want,
                         input logic gv, input logic wv);
        n_cmp++;
        if (got !== want || gv !== wv) begin
            n_bad++;
            $display("FAIL %s: data_out=%b valid=%b expected data_out=%b valid=%b",
                     tag, got, gv, want, wv);
        end
    endtask

    // One cycle: compare the word due now, then drive new inputs.
    task automatic step(input logic [3:0] d, input logic m, input logic s, input string tag);
        check(exp_t[1], data_out, exp_d[1], out_valid, exp_v[1]);
        if (capturing) begin
            gray_cap[cap_idx] = data_out;
            cap_idx++;
        end
        exp_d[1] = exp_d[0];
        exp_v[1] = exp_v[0];
        exp_t[1] = exp_t[0];
        exp_d[0] = m ? ref_dec(d) : ref_enc(d);
        exp_v[0] = s;
        exp_t[0] = tag;
        data_in   = d;
        mode_dec  = m;
        in_strobe = s;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        logic [3:0] rd;
        seed = 32'd2024;
        void'($urandom(seed));

        // R1: reset with busy inputs still clears the outputs.
        rst = 1'b1; data_in = 4'hF; mode_dec = 1'b1; in_strobe = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", data_out, 4'h0, out_valid, 1'b0);
        rst = 1'b0;
        for (int k = 0; k < 2; k++) begin
            exp_d[k] = 4'h0; exp_v[k] = 1'b0; exp_t[k] = "R1";
        end

        // R4: the worked examples.
        step(4'b0110, 1'b0, 1'b1, "R4");
        step(4'b0101, 1'b1, 1'b1, "R4");
        step(4'b0101, 1'b0, 1'b1, "R4");
        // R6: same word, direction flips on the next cycle.
        step(4'b1011, 1'b0, 1'b1, "R6");
        step(4'b1011, 1'b1, 1'b1, "R6");
        step(4'b1011, 1'b0, 1'b1, "R6");
        // R9: unstrobed words still convert but stay invalid.
        step(4'b1100, 1'b0, 1'b0, "R9");
        step(4'b1110, 1'b1, 1'b0, "R9");
        // R5: isolated strobe between quiet cycles.
        step(4'b0000, 1'b0, 1'b0, "R5");
        step(4'b1001, 1'b1, 1'b1, "R5");
        step(4'b0000, 1'b0, 1'b0, "R5");
        step(4'b0000, 1'b0, 1'b0, "R5");

        // R2 / R8: encode sweep 0..15 then 0 again; codes are kept.
        for (int v = 0; v <= 16; v++) begin
            step(4'(v % 16), 1'b0, 1'b1, "R2");
            if (v == 1) capturing = 1'b1;
        end
        step(4'h0, 1'b0, 1'b0, "R2");
        step(4'h0, 1'b0, 1'b0, "R2");
        capturing = 1'b0;

        // R8: neighbouring codes from the design differ in one bit.
        for (int v = 0; v < 16; v++) begin
            n_cmp++;
            if (gray_pkg::ones_in(gray_cap[v] ^ gray_cap[v+1]) != 1) begin
                n_bad++;
                $display("FAIL R8: codes %b and %b differ in %0d bits expected 1",
                         gray_cap[v], gray_cap[v+1],
                         gray_pkg::ones_in(gray_cap[v] ^ gray_cap[v+1]));
            end
        end

        // R7: decode each captured code and expect the original value.
        for (int v = 0; v < 16; v++) begin
            step(gray_cap[v], 1'b1, 1'b1, "R7");
            if (ref_dec(gray_cap[v]) != 4'(v)) begin
                n_cmp++; n_bad++;
                $display("FAIL R7: code %b decodes to %b expected %b",
                         gray_cap[v], ref_dec(gray_cap[v]), 4'(v));
            end
        end

        // R3: decode sweep over all Gray words.
        for (int v = 0; v < 16; v++) step(4'(v), 1'b1, 1'b1, "R3");

        // R2 / R3 / R5: random mix of words, directions and strobes.
        for (int n = 0; n < 200; n++) begin
            rd = 4'($urandom);
            step(rd, 1'($urandom), 1'($urandom), "R5");
        end

        // Drain the two pending results.
        step(4'h0, 1'b0, 1'b0, "R5");
        step(4'h0, 1'b0, 1'b0, "R5");
        check(exp_t[1], data_out, exp_d[1], out_valid, exp_v[1]);

        // R1: reset in mid-stream clears the outputs again.
        step(4'h7, 1'b1, 1'b1, "R1");
        rst = 1'b1;
        @(negedge clk);
        check("R1", data_out, 4'h0, out_valid, 1'b0);
        rst = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule